// File: doc/BRIEF.md
# Four-Bit Multi-Function Computational Unit

This block takes two 4-bit unsigned operands and a 3-bit operation code. It computes one of eight results: bitwise XOR, bitwise XNOR, the full product, the sum, the difference, a right rotation, a three-way magnitude comparison or an equality test. A decoder in the control section turns the operation code into one-hot select strobes. An AND-OR multiplexer in the datapath uses those strobes to pick one result. The chosen result is registered onto an 8-bit result bus, together with a carry/borrow flag and a zero flag.

A producer presents the operands and code with `validIn` high. One clock later `validOut` is high and the outputs show the result of that operation. While `validIn` is low, the result registers keep their previous value.

Top module: `nib_calc_unit`

## Requirements
- R1: After reset, `validOut`, `result`, `carryOut` and `zeroFlag` are all 0.
- R2: A cycle with `validIn` high produces `validOut` high on the next clock, carrying that cycle's result. A cycle with `validIn` low produces `validOut` low on the next clock.
- R3: Code 0 (XOR) gives `result = {4'b0, a ^ b}`. Code 1 (XNOR) gives `result = {4'b0, ~(a ^ b)}`.
- R4: Code 2 (multiply) gives the full unsigned 8-bit product `a * b` on `result`.
- R5: Code 3 (add) gives the 4-bit sum modulo 16 in `result[3:0]` with `result[7:4] = 0`. `carryOut` equals bit 4 of the 5-bit sum.
- R6: Code 4 (subtract) gives `(a - b) mod 16` in `result[3:0]` with `result[7:4] = 0`. `carryOut` is 1 (borrow) exactly when `a < b` unsigned.
- R7: Code 5 (rotate right) gives A rotated right by `b[1:0]` positions in `result[3:0]`, with bits that leave bit 0 entering at bit 3, and `result[7:4] = 0`.
- R8: Code 6 (magnitude compare) gives `result[1:0]` = 01 when a < b, 00 when a == b and 10 when a > b, with `result[7:2] = 0`.
- R9: Code 7 (equality) gives `result[0] = 1` when a == b and 0 otherwise, with `result[7:1] = 0`.
- R10: `carryOut` is 0 for every code other than 3 and 4.
- R11: `zeroFlag` is 1 exactly when the registered `result` is all zeros.
- R12: While `validIn` is low, `result`, `carryOut` and `zeroFlag` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operands and code are valid this cycle |
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| opCode | input | 3 | Operation select, 0..7 as listed in R3 to R9 |
| validOut | output | 1 | Result registers were loaded on the last clock |
| result | output | 8 | Registered result |
| carryOut | output | 1 | Carry (add) or borrow (subtract) |
| zeroFlag | output | 1 | Registered result is zero |

## Verification
Every operation code is applied with all 256 operand pairs. This makes each operation meet its own edge cases: the 15x15 product, carries out of 15+15, borrows where B exceeds A, every rotation amount with the upper bits of B set or clear, and equal against unequal pairs for both comparators. A table of directed vectors pins down known results, so that an operation-code mapping moved by one cannot match a model that has the same mistake. Stalls with the inputs changed behind a low `validIn` separate true holding of the result from results that merely happen to be the same.

// File: rtl/nib_calc_pkg.sv
package nib_calc_pkg;
  localparam int DATA_W  = 4;
  localparam int RES_W   = 2 * DATA_W;
  localparam int OP_W    = 3;
  localparam int NUM_OPS = 1 << OP_W;
  localparam int ROT_W   = $clog2(DATA_W);

  typedef enum logic [OP_W-1:0] {
    OP_XOR  = 3'd0,
    OP_XNOR = 3'd1,
    OP_MUL  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_ROR  = 3'd5,
    OP_MAG  = 3'd6,
    OP_EQ   = 3'd7
  } calcOp_e;

  typedef struct packed {
    logic               load;
    logic [NUM_OPS-1:0] sel;
  } calcStrobes_t;
endpackage

// File: rtl/nib_calc_ctrl.sv
module nib_calc_ctrl
  import nib_calc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [OP_W-1:0] opCode,
  output calcStrobes_t    strobes,
  output logic            validOut
);
  logic [NUM_OPS-1:0] decoded;

  // One-hot decoder: one select line per operation code
  always_comb begin
    decoded = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (opCode == OP_W'(i)) decoded[i] = 1'b1;
    end
  end

  assign strobes.load = validIn;
  assign strobes.sel  = validIn ? decoded : '0;

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/nib_calc_dp.sv
module nib_calc_dp
  import nib_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calcStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [RES_W-1:0]  result,
  output logic              carryOut,
  output logic              zeroFlag
);
  localparam int PAD_W = RES_W - DATA_W;

  logic [RES_W-1:0]    opRes [NUM_OPS];
  logic [NUM_OPS-1:0]  opCarry;
  logic [DATA_W:0]     sumWide;
  logic [DATA_W:0]     diffWide;
  logic [2*DATA_W-1:0] rotPair;
  logic [DATA_W-1:0]   rotA;
  logic [RES_W-1:0]    magCode;

  always_comb begin
    sumWide  = {1'b0, opA} + {1'b0, opB};
    diffWide = {1'b0, opA} - {1'b0, opB};
    rotPair  = {opA, opA} >> opB[ROT_W-1:0];
    rotA     = rotPair[DATA_W-1:0];
    magCode  = '0;
    if (opA < opB)      magCode[0] = 1'b1;
    else if (opA > opB) magCode[1] = 1'b1;
  end

  always_comb begin
    opRes[OP_XOR]  = {{PAD_W{1'b0}}, opA ^ opB};
    opRes[OP_XNOR] = {{PAD_W{1'b0}}, ~(opA ^ opB)};
    opRes[OP_MUL]  = RES_W'(opA) * RES_W'(opB);
    opRes[OP_ADD]  = {{PAD_W{1'b0}}, sumWide[DATA_W-1:0]};
    opRes[OP_SUB]  = {{PAD_W{1'b0}}, diffWide[DATA_W-1:0]};
    opRes[OP_ROR]  = {{PAD_W{1'b0}}, rotA};
    opRes[OP_MAG]  = magCode;
    opRes[OP_EQ]   = {{(RES_W-1){1'b0}}, opA == opB};
    opCarry          = '0;
    opCarry[OP_ADD]  = sumWide[DATA_W];
    opCarry[OP_SUB]  = diffWide[DATA_W];
  end

  // AND-OR output multiplexer driven by the one-hot strobes
  logic [RES_W-1:0]   masked [NUM_OPS];
  logic [NUM_OPS-1:0] carryMasked;
  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_mask
      assign masked[g]      = opRes[g] & {RES_W{strobes.sel[g]}};
      assign carryMasked[g] = opCarry[g] & strobes.sel[g];
    end
  endgenerate

  logic [RES_W-1:0] muxRes;
  always_comb begin
    muxRes = '0;
    for (int i = 0; i < NUM_OPS; i++) muxRes = muxRes | masked[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      carryOut <= 1'b0;
      zeroFlag <= 1'b0;
    end else if (strobes.load) begin
      result   <= muxRes;
      carryOut <= |carryMasked;
      zeroFlag <= (muxRes == '0);
    end
  end
endmodule

// File: rtl/nib_calc_unit.sv
module nib_calc_unit
  import nib_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  output logic              validOut,
  output logic [RES_W-1:0]  result,
  output logic              carryOut,
  output logic              zeroFlag
);
  calcStrobes_t strobes;

  nib_calc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .opCode   (opCode),
    .strobes  (strobes),
    .validOut (validOut)
  );

  nib_calc_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .zeroFlag (zeroFlag)
  );
endmodule

// File: rtl/nib_calc_unit_chk.sv
module nib_calc_unit_chk
  import nib_calc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [OP_W-1:0]   opCode,
  input logic              validOut,
  input logic [RES_W-1:0]  result,
  input logic              carryOut,
  input logic              zeroFlag
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  a_r4_product: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode == OP_MUL) |=> result == RES_W'($past(opA)) * RES_W'($past(opB)));

  a_r8_mag_code: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode == OP_MAG) |=> (result[RES_W-1:2] == '0 && result[1:0] != 2'b11));

  a_r9_eq_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode == OP_EQ) |=> result[RES_W-1:1] == '0);

  a_r10_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode != OP_ADD && opCode != OP_SUB) |=> !carryOut);

  a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (zeroFlag == (result == '0)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(result) && $stable(carryOut) && $stable(zeroFlag)));
endmodule

bind nib_calc_unit nib_calc_unit_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .opA      (opA),
  .opB      (opB),
  .opCode   (opCode),
  .validOut (validOut),
  .result   (result),
  .carryOut (carryOut),
  .zeroFlag (zeroFlag)
);

// File: tb/nib_calc_unit_tb_top.sv
module nib_calc_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       validIn;
  logic [3:0] opA;
  logic [3:0] opB;
  logic [2:0] opCode;
  logic       validOut;
  logic [7:0] result;
  logic       carryOut;
  logic       zeroFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  nib_calc_unit dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opA(opA), .opB(opB),
    .opCode(opCode), .validOut(validOut), .result(result),
    .carryOut(carryOut), .zeroFlag(zeroFlag)
  );

  // Directed vectors: {op[2:0], a[3:0], b[3:0], result[7:0], carry}
  localparam logic [19:0] VEC [12] = '{
    {3'd0, 4'hA, 4'h6, 8'h0C, 1'b0},  // XOR
    {3'd1, 4'hA, 4'h6, 8'h03, 1'b0},  // XNOR
    {3'd2, 4'hF, 4'hF, 8'hE1, 1'b0},  // 15*15
    {3'd2, 4'h7, 4'h0, 8'h00, 1'b0},
    {3'd3, 4'hF, 4'h1, 8'h00, 1'b1},  // carry out
    {3'd3, 4'h5, 4'h6, 8'h0B, 1'b0},
    {3'd4, 4'h3, 4'h5, 8'h0E, 1'b1},  // borrow
    {3'd4, 4'h9, 4'h2, 8'h07, 1'b0},
    {3'd5, 4'h1, 4'hD, 8'h08, 1'b0},  // rotate by 1 (b[1:0]=01)
    {3'd6, 4'h2, 4'h9, 8'h01, 1'b0},  // less
    {3'd6, 4'hC, 4'h4, 8'h02, 1'b0},  // greater
    {3'd7, 4'h6, 4'h6, 8'h01, 1'b0}   // equal
  };

  function automatic logic [8:0] model(input logic [2:0] op, input logic [3:0] a,
                                       input logic [3:0] b);
    logic [7:0] r;
    logic       c;
    logic [4:0] w;
    r = 8'h00;
    c = 1'b0;
    case (op)
      3'd0: r = {4'h0, a ^ b};
      3'd1: r = {4'h0, ~(a ^ b)};
      3'd2: r = {4'h0, a} * {4'h0, b};
      3'd3: begin w = {1'b0, a} + {1'b0, b}; r = {4'h0, w[3:0]}; c = w[4]; end
      3'd4: begin w = {1'b0, a} - {1'b0, b}; r = {4'h0, w[3:0]}; c = (a < b); end
      3'd5: begin
        r[3:0] = a;
        for (int k = 0; k < 4; k++) if (k < int'(b[1:0])) r[3:0] = {r[0], r[3:1]};
      end
      3'd6: r = (a < b) ? 8'h01 : ((a > b) ? 8'h02 : 8'h00);
      default: r = {7'h0, a == b};
    endcase
    return {c, r};
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one operation, then sample the registered outputs at the next falling edge
  task automatic runOp(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [7:0] expR, input logic expC);
    validIn = 1'b1; opCode = op; opA = a; opB = b;
    @(negedge clk);
    check({tagOf(op), " R2 R10 R11"}, {21'h0, validOut, result, carryOut, zeroFlag},
          {21'h0, 1'b1, expR, expC, expR == 8'h00});
  endtask

  initial begin
    logic [7:0] holdR;
    logic       holdC;
    logic       holdZ;
    logic [8:0] m;
    rstN = 1'b0; validIn = 1'b0; opA = '0; opB = '0; opCode = '0;
    repeat (3) @(negedge clk);
    check("R1", {22'h0, validOut, result, carryOut}, 32'h0);
    check("R1 zero", {31'h0, zeroFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle", {31'h0, validOut}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      runOp(VEC[i][19:17], VEC[i][16:13], VEC[i][12:9], VEC[i][8:1], VEC[i][0]);
    end

    // Exhaustive sweep, back to back
    for (int op = 0; op < 8; op++) begin
      for (int ab = 0; ab < 256; ab++) begin
        m = model(3'(op), 4'(ab >> 4), 4'(ab));
        runOp(3'(op), 4'(ab >> 4), 4'(ab), m[7:0], m[8]);
      end
    end

    // R12: hold while validIn is low and the inputs change
    runOp(3'd3, 4'hF, 4'h3, 8'h02, 1'b1);
    holdR = result; holdC = carryOut; holdZ = zeroFlag;
    validIn = 1'b0; opCode = 3'd2; opA = 4'h0; opB = 4'h9;
    @(negedge clk);
    check("R12 stall1", {22'h0, validOut, result, carryOut, zeroFlag},
          {22'h0, 1'b0, holdR, holdC, holdZ});
    opCode = 3'd7; opA = 4'h4; opB = 4'h4;
    @(negedge clk);
    check("R12 stall2", {22'h0, validOut, result, carryOut, zeroFlag},
          {22'h0, 1'b0, holdR, holdC, holdZ});
    runOp(3'd7, 4'h4, 4'h5, 8'h00, 1'b0);

    // R1: reset in the middle of a run
    validIn = 1'b1; opCode = 3'd2; opA = 4'hF; opB = 4'hF;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid", {21'h0, validOut, result, carryOut, zeroFlag}, 32'h0);
    rstN = 1'b1; validIn = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule